// File: doc/BRIEF.md
# Triangle, Square and Echo Test-Pattern Generator

This block produces three 12-bit test codes for a four-channel digital-to-analogue converter, advancing one step each time a sample strobe arrives. The first code is a symmetric triangle that climbs and descends in fixed increments. The second code is a square wave that sits for two samples at a low preset code and then two samples at a high preset code. The third code echoes a 12-bit field taken from the 32-bit word that the converter shifted back during the previous transfer, so it trails the square channel by one sample.

A 16-bit sample counter advances on every strobe. It sets the square-wave phase, and its upper byte drives an 8-bit activity output, for example a row of LEDs. Everything runs on a single clock with a synchronous active-low reset. Between strobes every output holds its value.

Top module: `waveform_tester`

## Requirements
- R1: While reset is low at a clock edge, all four outputs become zero on that edge, the triangle direction returns to rising and the sample counter returns to zero.
- R2: On a clock edge where the strobe is low, no output changes.
- R3: On a strobe while rising, the triangle code increases by exactly 204.
- R4: On a strobe while falling, the triangle code decreases by exactly 204.
- R5: The direction becomes falling when the triangle reaches 4080, and rising when it reaches 0. The code never exceeds 4080.
- R6: Starting from reset, the triangle reads 4080 after the 20th strobe and 0 after the 40th. The 41st strobe gives 204, so one period is 40 samples.
- R7: On each strobe the square output takes 0x333 if bit 1 of the sample counter (its value before that strobe) is 0, and 0xCCD if that bit is 1. After reset this gives low, low, high, high, repeating.
- R8: On each strobe the echo output takes bits [15:4] of the 32-bit readback input.
- R9: The sample counter increments by one per strobe and wraps from 65535 to 0. The activity output equals bits [15:8] of the counter after the increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_en | input | 1 | Sample strobe, one clock wide per sample |
| rdbk_word | input | 32 | Word shifted back by the converter on the previous transfer |
| tri_code | output | 12 | Triangle test code |
| sqr_code | output | 12 | Square test code |
| echo_code | output | 12 | 12-bit field of the readback word |
| activity | output | 8 | Upper byte of the sample counter |

## Verification
On every cycle, the assertions check that outputs hold when no strobe arrives, that the triangle stays within range and turns at both ends, that the square output only ever carries a legal code, and that the counter and echo follow the strobe. Several properties can only be shown by the bench's scenarios: the exact 40-sample period counted from reset, the low-low-high-high phase of the square after reset, and the counter wrapping back to zero after 65536 strobes.

// File: rtl/wt_pkg.sv
// Shared types and constants for the waveform tester.
// Assumes 12-bit converter codes.
package wt_pkg;
    typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} slope_t;
    localparam int CODE_W = 12;
endpackage

// File: rtl/wt_triangle.sv
// Triangle ramp: moves by STEP on each strobe, turning at PEAK and at zero.
// Assumes PEAK is a whole multiple of STEP, so both turn points are reached exactly.
module wt_triangle
    import wt_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int STEP   = 204,
    parameter int PEAK   = 4080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic [DATA_W-1:0] code
);
    localparam logic [DATA_W-1:0] STEP_C = DATA_W'(STEP);
    localparam logic [DATA_W-1:0] PEAK_C = DATA_W'(PEAK);

    slope_t            dir_q;
    logic [DATA_W-1:0] val_q;
    logic [DATA_W-1:0] val_d;

    // Next ramp value for the current slope.
    always_comb begin
        val_d = (dir_q == DIR_UP) ? val_q + STEP_C : val_q - STEP_C;
    end

    // Ramp register and slope flag, updated on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            dir_q <= DIR_UP;
        end else if (en) begin
            val_q <= val_d;
            if (dir_q == DIR_UP && val_d == PEAK_C)
                dir_q <= DIR_DOWN;
            else if (dir_q == DIR_DOWN && val_d == '0)
                dir_q <= DIR_UP;
        end
    end

    assign code = val_q;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(val_q));
    assert_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= PEAK_C);
    assert_turn_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir_q == DIR_UP && val_q == PEAK_C - STEP_C) |=> dir_q == DIR_DOWN);
    assert_turn_bot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir_q == DIR_DOWN && val_q == STEP_C) |=> dir_q == DIR_UP);
    assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir_q == DIR_UP) |=> val_q == $past(val_q) + STEP_C);
    assert_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dir_q == DIR_DOWN) |=> val_q == $past(val_q) - STEP_C);
endmodule

// File: rtl/wt_counter.sv
// Free-running sample counter; advances once per strobe and wraps.
// Assumes ACT_W is not wider than CNT_W.
module wt_counter #(
    parameter int CNT_W = 16,
    parameter int ACT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic [ACT_W-1:0] act
);
    logic [CNT_W-1:0] cnt_q;

    // Count strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (en) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;
    assign act   = cnt_q[CNT_W-1 -: ACT_W];

    assert_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt_q));
endmodule

// File: rtl/wt_square.sv
// Square pattern: chooses a low or high preset from one phase bit of the counter.
// Assumes the phase bit comes from the counter value before the current strobe.
module wt_square #(
    parameter int              DATA_W = 12,
    parameter logic [DATA_W-1:0] LO_CODE = 12'h333,
    parameter logic [DATA_W-1:0] HI_CODE = 12'hCCD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              phase,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] sq_q;

    // Load the preset chosen by the phase bit.
    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else if (en) sq_q <= phase ? HI_CODE : LO_CODE;
    end

    assign code = sq_q;

    assert_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q == '0 || sq_q == LO_CODE || sq_q == HI_CODE);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sq_q));
endmodule

// File: rtl/wt_echo.sv
// Echo channel: captures a field of the readback word on each strobe.
// Assumes the field lies inside the readback word.
module wt_echo #(
    parameter int RB_W   = 32,
    parameter int DATA_W = 12,
    parameter int LSB    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [RB_W-1:0]   rdbk,
    output logic [DATA_W-1:0] code
);
    logic [DATA_W-1:0] ec_q;

    // Capture the code field from the readback.
    always_ff @(posedge clk) begin
        if (!rst_n) ec_q <= '0;
        else if (en) ec_q <= rdbk[LSB +: DATA_W];
    end

    assign code = ec_q;

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ec_q == $past(rdbk[LSB +: DATA_W]));
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(ec_q));
endmodule

// File: rtl/waveform_tester.sv
// Top level: triangle, square and echo test codes with an activity byte.
// Assumes smp_en is one clock wide per sample. Reset is synchronous and active low.
module waveform_tester #(
    parameter int DATA_W = 12,
    parameter int STEP   = 204,
    parameter int PEAK   = 4080,
    parameter int CNT_W  = 16,
    parameter int ACT_W  = 8,
    parameter int RB_W   = 32,
    parameter int ECHO_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_en,
    input  logic [RB_W-1:0]   rdbk_word,
    output logic [DATA_W-1:0] tri_code,
    output logic [DATA_W-1:0] sqr_code,
    output logic [DATA_W-1:0] echo_code,
    output logic [ACT_W-1:0]  activity
);
    logic [CNT_W-1:0] count;

    wt_triangle #(.DATA_W(DATA_W), .STEP(STEP), .PEAK(PEAK)) u_tri (
        .clk(clk), .rst_n(rst_n), .en(smp_en), .code(tri_code));

    wt_counter #(.CNT_W(CNT_W), .ACT_W(ACT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(smp_en), .count(count), .act(activity));

    wt_square #(.DATA_W(DATA_W)) u_sq (
        .clk(clk), .rst_n(rst_n), .en(smp_en), .phase(count[1]), .code(sqr_code));

    wt_echo #(.RB_W(RB_W), .DATA_W(DATA_W), .LSB(ECHO_LSB)) u_echo (
        .clk(clk), .rst_n(rst_n), .en(smp_en), .rdbk(rdbk_word), .code(echo_code));

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (tri_code == '0 && sqr_code == '0 && echo_code == '0 && activity == '0));
endmodule

// File: tb/test_waveform_tester.sv
module test_waveform_tester;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0;
    logic [31:0] rdbk_word = '0;
    logic [11:0] tri_code, sqr_code, echo_code;
    logic [7:0]  activity;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // model state
    int  m_tri = 0;
    bit  m_up = 1;
    int  m_cnt = 0;
    int  m_sq = 0;
    int  m_echo = 0;
    string tri_tag = "R3";

    always #10 clk = ~clk;

    waveform_tester i_waveform_tester (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .rdbk_word(rdbk_word),
        .tri_code(tri_code), .sqr_code(sqr_code), .echo_code(echo_code),
        .activity(activity));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int sq_code(input int cnt);
        return ((cnt >> 1) & 1) ? 'hCCD : 'h333;
    endfunction

    // One clock: drive at negedge, update model at posedge, compare 5 ns later.
    task automatic step(input bit en, input logic [31:0] rb);
        string ht;
        @(negedge clk);
        smp_en = en;
        rdbk_word = rb;
        @(posedge clk);
        if (!rst_n) begin
            m_tri = 0; m_up = 1; m_cnt = 0; m_sq = 0; m_echo = 0;
            ht = "R1"; tri_tag = "R1";
        end else if (en) begin
            m_sq = sq_code(m_cnt);
            m_cnt = (m_cnt + 1) & 'hFFFF;
            m_echo = int'(rb[15:4]);
            if (m_up) begin
                m_tri += 204; tri_tag = "R3";
                if (m_tri == 4080) begin m_up = 0; tri_tag = "R5"; end
            end else begin
                m_tri -= 204; tri_tag = "R4";
                if (m_tri == 0) begin m_up = 1; tri_tag = "R5"; end
            end
            ht = "";
        end else begin
            ht = "R2"; tri_tag = "R2";
        end
        #5;
        chk(tri_tag, int'(tri_code), m_tri);
        chk((ht == "") ? "R7" : ht, int'(sqr_code), m_sq);
        chk((ht == "") ? "R8" : ht, int'(echo_code), m_echo);
        chk((ht == "") ? "R9" : ht, int'(activity), (m_cnt >> 8) & 'hFF);
    endtask

    task automatic do_reset();
        rst_n = 0;
        step(1, 32'hFFFF_FFFF);
        step(0, 32'h0);
        // R1: reset state visible at all outputs
        chk("R1", int'(tri_code | sqr_code | echo_code | 12'(activity)), 0);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        void'($urandom(32'd5150));
        do_reset();
        // R7: directed square phase after reset
        for (int i = 0; i < 8; i++) begin
            step(1, 32'h0000_1230 + 32'(i << 4));
            chk("R7", int'(sqr_code), (i % 4 < 2) ? 'h333 : 'hCCD);
        end
        // R6: period of 40 from reset
        do_reset();
        for (int i = 1; i <= 41; i++) begin
            step(1, $urandom);
            if (i == 20) chk("R6", int'(tri_code), 4080);
            if (i == 40) chk("R6", int'(tri_code), 0);
            if (i == 41) chk("R6", int'(tri_code), 204);
        end
        // R2..R8: random strobes and readback words
        for (int i = 0; i < 400; i++) step(($urandom % 3) != 0, $urandom);
        // R2: long idle gap, including changing readback
        for (int i = 0; i < 10; i++) step(0, $urandom);
        // R9: full counter wrap with strobes every cycle
        do_reset();
        for (int i = 0; i < 65536; i++) step(1, $urandom);
        chk("R9", int'(activity), 0);
        step(1, 32'h0000_ABC0);
        chk("R8", int'(echo_code), 'hABC);
        chk("R7", int'(sqr_code), 'h333);
        // R1: reset in mid-run
        do_reset();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule